// File: doc/BRIEF.md
# SD host event status and interrupt controller

This block holds the event status word and the interrupt-enable word of an SD card host. Single-cycle event pulses from the command engine, the data path, the double buffer and the card-detect logic land in sticky bits that stay set until software writes a one to them. Two buffer-ready flags are shown as live levels, and the two-bit write-CRC status that the card returns after a write block is captured in a small field of its own.

An enable word selects which status bits may raise the single interrupt line; the line is registered so that it never glitches. A separate error flag gives the rest of the host a quick view of whether any error bit is set, without decoding the whole word. Software reaches both words through one 32-bit read/write port with a byte offset. Reads are combinational from the addressed word.

Top module: `sdh_event_ctl`

## Requirements
- R1: With `rst` high at a clock edge, all sticky bits, the CRC status field and the whole enable word become zero, and `irq` goes low.
- R2: A one on `ev_pulse[k]` at a clock edge sets status bit k when k is a sticky position (31 to 24, 14 to 11, 5, 3, 2, 1, 0); the bit then stays set while no clearing write reaches it.
- R3: A write to offset 0x04 clears each sticky bit whose data bit is one and leaves the bits whose data bit is zero unchanged.
- R4: When an event pulse and a clearing write hit the same sticky bit at the same edge, the bit ends up set.
- R5: Status bit 7 equals `buf_rd_rdy` and status bit 6 equals `buf_wr_rdy` in the same cycle; writes to offset 0x04 have no effect on them.
- R6: Status bits 10:9 take `crc_stat` at an edge where `crc_stat_vld` is high (value 2 means the card sent no CRC status); a write to offset 0x04 with a one in bit 9 or 10 zeroes the field, and a capture at the same edge wins over that clear.
- R7: Offset 0x24 holds the enable word: a write stores the data ANDed with 0x0007_F01F and a read returns it; any other offset except 0x04 reads zero and its writes change nothing.
- R8: `irq` is high in the cycle after an edge at which at least one of these enable/status pairs had both bits set: 15/31, 14/30, 13/14, 4/7, 3/6, 2/13, 1/12, 0/11; otherwise it is low in that cycle.
- R9: `err_any` is high exactly when any of status bits 5, 3, 2, 1 or 0 is set.
- R10: Status bits 23 to 15, 8 and 4 always read zero, whatever the event pulses are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Byte offset of the accessed word |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word |
| ev_pulse | input | 32 | Event pulses, one per status bit position |
| buf_rd_rdy | input | 1 | Live level: buffer holds data to read |
| buf_wr_rdy | input | 1 | Live level: buffer can take data |
| crc_stat_vld | input | 1 | Capture strobe for the card CRC status |
| crc_stat | input | 2 | Card CRC status code |
| irq | output | 1 | Registered interrupt request |
| err_any | output | 1 | High while any error status bit is set |

## Verification
Event pulses are first sent one position at a time and then all at once, which separates a wrong bit position from a wrong sticky mask and shows that reserved positions stay zero. Clearing writes with partial patterns, and writes that coincide with a pulse on the same bit, tell a correct write-one-to-clear from a plain overwrite and from a clear that wins. The interrupt is driven by one enable/status pair at a time, including a live buffer level, so a swapped pairing or a missing register stage shows up; a long run of random pulses, writes, levels and CRC captures is compared cycle by cycle against a behavioural model.

// File: rtl/sdh_evt_pkg.sv
package sdh_evt_pkg;

    localparam int REG_W      = 32;
    localparam int CODE_W     = 2;
    localparam int CODE_LSB   = 9;
    localparam int BIT_RD_RDY = 7;
    localparam int BIT_WR_RDY = 6;
    localparam int N_IRQ_SRC  = 8;

    localparam logic [REG_W-1:0] STICKY_MASK = 32'hFF00_782F;
    localparam logic [REG_W-1:0] ERR_MASK    = 32'h0000_002F;
    localparam logic [REG_W-1:0] EN_MASK     = 32'h0007_F01F;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_IRQEN
    } reg_sel_e;

    typedef struct packed {
        logic             wr_status;
        logic             wr_irqen;
        logic [REG_W-1:0] data;
    } reg_wr_t;

    // enable bit that gates interrupt source i
    function automatic int src_en_bit(input int i);
        case (i)
            0:       return 15;
            1:       return 14;
            2:       return 13;
            3:       return 4;
            4:       return 3;
            5:       return 2;
            6:       return 1;
            default: return 0;
        endcase
    endfunction

    // status bit that feeds interrupt source i
    function automatic int src_st_bit(input int i);
        case (i)
            0:       return 31;
            1:       return 30;
            2:       return 14;
            3:       return 7;
            4:       return 6;
            5:       return 13;
            6:       return 12;
            default: return 11;
        endcase
    endfunction

    function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
        case (ofs)
            8'h04:   return SEL_STATUS;
            8'h24:   return SEL_IRQEN;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/sdh_addr_dec.sv
module sdh_addr_dec
    import sdh_evt_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [REG_W-1:0]  wdata,
    input  logic [REG_W-1:0]  status_word,
    input  logic [REG_W-1:0]  en_word,
    output reg_wr_t           wr,
    output logic [REG_W-1:0]  rdata
);
    reg_sel_e sel;

    always_comb begin
        sel = decode_ofs(8'(addr));
        wr.wr_status = we && (sel == SEL_STATUS);
        wr.wr_irqen  = we && (sel == SEL_IRQEN);
        wr.data      = wdata;
        case (sel)
            SEL_STATUS: rdata = status_word;
            SEL_IRQEN:  rdata = en_word;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/sdh_status_bank.sv
module sdh_status_bank
    import sdh_evt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  reg_wr_t              wr,
    input  logic [REG_W-1:0]     ev_pulse,
    input  logic                 buf_rd_rdy,
    input  logic                 buf_wr_rdy,
    input  logic                 crc_stat_vld,
    input  logic [CODE_W-1:0]    crc_stat,
    output logic [REG_W-1:0]     status_word,
    output logic [N_IRQ_SRC-1:0] irq_src,
    output logic                 err_any
);
    logic [REG_W-1:0]  sticky_q, sticky_d, clr_vec, set_vec;
    logic [CODE_W-1:0] code_q, code_d;
    logic              code_clr;

    always_comb begin
        set_vec  = ev_pulse & STICKY_MASK;
        clr_vec  = wr.wr_status ? (wr.data & STICKY_MASK) : '0;
        sticky_d = (sticky_q & ~clr_vec) | set_vec;
        code_clr = wr.wr_status && (|wr.data[CODE_LSB +: CODE_W]);
        if (crc_stat_vld)  code_d = crc_stat;
        else if (code_clr) code_d = '0;
        else               code_d = code_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sticky_q <= '0;
            code_q   <= '0;
        end else begin
            sticky_q <= sticky_d;
            code_q   <= code_d;
        end
    end

    always_comb begin
        status_word = sticky_q
                    | (REG_W'(code_q) << CODE_LSB)
                    | (REG_W'(buf_rd_rdy) << BIT_RD_RDY)
                    | (REG_W'(buf_wr_rdy) << BIT_WR_RDY);
        err_any = |(sticky_q & ERR_MASK);
    end

    for (genvar i = 0; i < N_IRQ_SRC; i++) begin : g_src
        localparam int SB = src_st_bit(i);
        assign irq_src[i] = status_word[SB];
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (sticky_q == '0 && code_q == '0));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr.wr_status |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

    assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
        wr.wr_status |=> ((sticky_q & $past(wr.data & STICKY_MASK & ~ev_pulse)) == '0));

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
        ((ev_pulse & STICKY_MASK) != '0)
        |=> ((sticky_q & $past(ev_pulse & STICKY_MASK)) == $past(ev_pulse & STICKY_MASK)));

    assert_crc_capture_R6: assert property (@(posedge clk) disable iff (rst)
        crc_stat_vld |=> (code_q == $past(crc_stat)));
endmodule

// File: rtl/sdh_irq_mask.sv
module sdh_irq_mask
    import sdh_evt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  reg_wr_t              wr,
    input  logic [N_IRQ_SRC-1:0] irq_src,
    output logic [REG_W-1:0]     en_word,
    output logic                 irq
);
    logic [REG_W-1:0]     en_q;
    logic [N_IRQ_SRC-1:0] hit;
    logic                 irq_q;

    for (genvar i = 0; i < N_IRQ_SRC; i++) begin : g_hit
        localparam int EB = src_en_bit(i);
        assign hit[i] = en_q[EB] & irq_src[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            irq_q <= 1'b0;
        end else begin
            if (wr.wr_irqen) en_q <= wr.data & EN_MASK;
            irq_q <= |hit;
        end
    end

    assign en_word = en_q;
    assign irq     = irq_q;

    assert_en_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !wr.wr_irqen |=> $stable(en_q));

    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> $past(|irq_src));
endmodule

// File: rtl/sdh_event_ctl.sv
module sdh_event_ctl
    import sdh_evt_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [31:0]       ev_pulse,
    input  logic              buf_rd_rdy,
    input  logic              buf_wr_rdy,
    input  logic              crc_stat_vld,
    input  logic [1:0]        crc_stat,
    output logic              irq,
    output logic              err_any
);
    reg_wr_t              wr;
    logic [REG_W-1:0]     status_word, en_word;
    logic [N_IRQ_SRC-1:0] irq_src;

    sdh_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr        (reg_addr),
        .we          (reg_we),
        .wdata       (reg_wdata),
        .status_word (status_word),
        .en_word     (en_word),
        .wr          (wr),
        .rdata       (reg_rdata)
    );

    sdh_status_bank u_status (
        .clk          (clk),
        .rst          (rst),
        .wr           (wr),
        .ev_pulse     (ev_pulse),
        .buf_rd_rdy   (buf_rd_rdy),
        .buf_wr_rdy   (buf_wr_rdy),
        .crc_stat_vld (crc_stat_vld),
        .crc_stat     (crc_stat),
        .status_word  (status_word),
        .irq_src      (irq_src),
        .err_any      (err_any)
    );

    sdh_irq_mask u_irq (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .irq_src (irq_src),
        .en_word (en_word),
        .irq     (irq)
    );
endmodule

// File: tb/tb_sdh_event_ctl.sv
`timescale 1ns/1ps
module tb_sdh_event_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] ev_pulse = '0;
    logic        buf_rd_rdy = 1'b0;
    logic        buf_wr_rdy = 1'b0;
    logic        crc_stat_vld = 1'b0;
    logic [1:0]  crc_stat = '0;
    logic        irq, err_any;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit live_cmp = 0;

    always #4 clk = ~clk;

    sdh_event_ctl dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_pulse(ev_pulse),
        .buf_rd_rdy(buf_rd_rdy), .buf_wr_rdy(buf_wr_rdy),
        .crc_stat_vld(crc_stat_vld), .crc_stat(crc_stat),
        .irq(irq), .err_any(err_any)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_st, m_en;
    logic [1:0]  m_code;
    logic        m_irq;
    int pe[8] = '{15, 14, 13, 4, 3, 2, 1, 0};
    int ps[8] = '{31, 30, 14, 7, 6, 13, 12, 11};

    function automatic bit is_sticky(int k);
        return (k >= 24) || (k >= 11 && k <= 14) || k == 5 || k == 3 || k <= 2;
    endfunction

    function automatic bit en_ok(int k);
        return (k >= 12 && k <= 18) || (k <= 4);
    endfunction

    function automatic logic [31:0] m_word();
        logic [31:0] w;
        w = m_st;
        w[10:9] = m_code;
        w[7] = buf_rd_rdy;
        w[6] = buf_wr_rdy;
        return w;
    endfunction

    function automatic logic [31:0] m_rdata();
        if (reg_addr == 8'h04) return m_word();
        if (reg_addr == 8'h24) return m_en;
        return 32'h0;
    endfunction

    always @(posedge clk) begin : model
        logic [31:0] w, nst, nen;
        logic [1:0]  ncode;
        logic        nirq;
        if (rst) begin
            m_st <= '0; m_en <= '0; m_code <= '0; m_irq <= 1'b0;
        end else begin
            w = m_word();
            nst = m_st;
            for (int k = 0; k < 32; k++) begin
                if (is_sticky(k)) begin
                    if (ev_pulse[k]) nst[k] = 1'b1;
                    else if (reg_we && reg_addr == 8'h04 && reg_wdata[k]) nst[k] = 1'b0;
                end
            end
            ncode = m_code;
            if (crc_stat_vld) ncode = crc_stat;
            else if (reg_we && reg_addr == 8'h04 && (reg_wdata[9] || reg_wdata[10])) ncode = 2'b00;
            nen = m_en;
            if (reg_we && reg_addr == 8'h24)
                for (int k = 0; k < 32; k++) nen[k] = reg_wdata[k] && en_ok(k);
            nirq = 1'b0;
            for (int p = 0; p < 8; p++) if (m_en[pe[p]] && w[ps[p]]) nirq = 1'b1;
            m_st <= nst; m_en <= nen; m_code <= ncode; m_irq <= nirq;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (live_cmp && !rst) begin
            chk(reg_addr == 8'h24 ? "R7 enable read" :
                reg_addr == 8'h04 ? "R2 status read" : "R7 other offset",
                reg_rdata, m_rdata());
            chk("R8 irq", 32'(irq), 32'(m_irq));
            chk("R9 err_any", 32'(err_any), 32'(|(m_st & 32'h2F)));
        end
    end

    task automatic tick();
        @(posedge clk); #1;
        ev_pulse = '0; reg_we = 1'b0; crc_stat_vld = 1'b0;
    endtask

    task automatic peek(logic [7:0] a, string req, logic [31:0] exp);
        reg_addr = a; #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        peek(8'h04, "R1 status after reset", 32'h0);
        peek(8'h24, "R1 enable after reset", 32'h0);
        chk("R1 irq after reset", 32'(irq), 32'h0);
        live_cmp = 1;

        // R2 single event, then held
        ev_pulse = 32'h8000_0000; tick();
        peek(8'h04, "R2 insertion set", 32'h8000_0000);
        tick(); tick();
        peek(8'h04, "R2 held", 32'h8000_0000);
        // R10 all pulses, reserved positions stay zero
        ev_pulse = 32'hFFFF_FFFF; tick();
        peek(8'h04, "R10 reserved zero", 32'hFF00_782F);
        // R3 partial clear
        wr(8'h04, 32'h0000_000F); tick();
        peek(8'h04, "R3 partial w1c", 32'hFF00_7820);
        chk("R9 err from bit5", 32'(err_any), 32'h1);
        wr(8'h04, 32'h0); tick();
        peek(8'h04, "R3 zero write keeps", 32'hFF00_7820);
        wr(8'h04, 32'hFFFF_FFFF); tick();
        peek(8'h04, "R3 full clear", 32'h0);
        chk("R9 err clear", 32'(err_any), 32'h0);
        // R4 set beats clear
        ev_pulse = 32'h0000_1000; wr(8'h04, 32'h0000_1000); tick();
        peek(8'h04, "R4 set wins", 32'h0000_1000);
        wr(8'h04, 32'h0000_1000); tick();
        // R5 live levels
        buf_rd_rdy = 1'b1;
        peek(8'h04, "R5 read ready live", 32'h0000_0080);
        buf_wr_rdy = 1'b1;
        peek(8'h04, "R5 both live", 32'h0000_00C0);
        wr(8'h04, 32'h0000_00C0); tick();
        peek(8'h04, "R5 write no effect", 32'h0000_00C0);
        buf_rd_rdy = 1'b0; buf_wr_rdy = 1'b0;
        peek(8'h04, "R5 levels low", 32'h0);
        // R6 CRC status field
        crc_stat_vld = 1'b1; crc_stat = 2'd2; tick();
        peek(8'h04, "R6 no-CRC code latched", 32'h0000_0400);
        wr(8'h04, 32'h0000_0200); tick();
        peek(8'h04, "R6 field cleared", 32'h0);
        crc_stat_vld = 1'b1; crc_stat = 2'd3; wr(8'h04, 32'h0000_0600); tick();
        peek(8'h04, "R6 capture wins", 32'h0000_0600);
        wr(8'h04, 32'h0000_0600); tick();
        // R7 enable word and other offsets
        wr(8'h24, 32'hFFFF_FFFF); tick();
        peek(8'h24, "R7 enable mask", 32'h0007_F01F);
        wr(8'h08, 32'hFFFF_FFFF); tick();
        peek(8'h08, "R7 other offset reads zero", 32'h0);
        peek(8'h24, "R7 other offset write ignored", 32'h0007_F01F);
        peek(8'h04, "R7 status untouched", 32'h0);
        // R8 interrupt pairing and latency
        wr(8'h24, 32'h0000_0004); tick();
        ev_pulse = 32'h0000_2000; tick();
        chk("R8 not yet", 32'(irq), 32'h0);
        tick();
        chk("R8 end-cmd irq", 32'(irq), 32'h1);
        wr(8'h04, 32'h0000_2000); ev_pulse = 32'h0000_1000; tick(); tick();
        chk("R8 disabled source quiet", 32'(irq), 32'h0);
        wr(8'h04, 32'hFFFF_FFFF); wr(8'h24, 32'h0000_0010); tick();
        buf_rd_rdy = 1'b1; tick();
        chk("R8 live source irq", 32'(irq), 32'h1);
        buf_rd_rdy = 1'b0; tick();
        chk("R8 live source drops", 32'(irq), 32'h0);

        // random traffic, compared every cycle
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            reg_addr = (r[1:0] == 0) ? 8'h24 : (r[1:0] == 1) ? 8'h08 : 8'h04;
            reg_we = (r[4:2] < 2);
            reg_wdata = $urandom;
            ev_pulse = $urandom & $urandom & $urandom;
            buf_rd_rdy = r[5]; buf_wr_rdy = r[6];
            crc_stat_vld = (r[9:7] == 0); crc_stat = r[11:10];
            @(posedge clk); #1;
        end
        ev_pulse = '0; reg_we = 1'b0; crc_stat_vld = 1'b0;
        rst = 1'b1; tick(); rst = 1'b0;
        peek(8'h04, "R1 status after late reset", {24'h0, buf_rd_rdy, buf_wr_rdy, 6'h0});
        peek(8'h24, "R1 enable after late reset", 32'h0);
        tick();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule